// File: doc/BRIEF.md
# Counter-Based Range Delay Checker

This block watches a single clocked rule: once a trigger is seen, the response signal must be high on at least one of the next N cycles. If the whole window passes without a response, it raises a one-cycle failure pulse. The block is built for large windows, where one register per window cycle would cost too much. It keeps one attempt alive at a time, using a small two-state controller and a binary cycle counter. An abort input and a kill input can cancel the attempt on any cycle. A cancelled attempt never reports a failure.

A trigger arriving while an attempt is active is dropped. It does not restart the count, and it is not queued. All pins are plain level signals sampled on the rising clock edge. The block has no data stream, so there is no handshake and no back-pressure. Reset is synchronous and active high.

Top module: `range_delay_chk`

## Requirements
- R1: While `rst_i` is high at a rising edge, the block returns to idle. `fail_o` is low in the cycle that follows, whatever the other inputs are doing. This holds even when reset lands in the middle of a window.
- R2: A trigger starts an attempt when three things are true in cycle t: the block is idle, `trig_i` is high, and both `dis_i` and `kill_i` are low. The window of that attempt is the N cycles t+1 through t+N.
- R3: If `resp_i` is high in any window cycle, from the first through the N-th, the attempt ends there and no failure is ever reported for it.
- R4: If `resp_i` stays low through all N window cycles, `fail_o` is high for exactly one cycle: cycle t+N+1. `fail_o` is low on every other cycle.
- R5: If `dis_i` is high in any window cycle, the attempt ends with no failure, even on the last window cycle. If `dis_i` is high in the trigger cycle, no attempt starts. `fail_o` is never high in the cycle right after a cycle with `dis_i` high.
- R6: `kill_i` follows the same rules as `dis_i`. High in a window cycle, it ends the attempt silently. High in the trigger cycle, it stops the attempt from starting.
- R7: A trigger that lands during an attempt's window is ignored. This includes a trigger on the window's final cycle. A new attempt may start on the cycle right after the attempt finishes.
- R8: `resp_i` in the trigger cycle itself does not satisfy the rule; only window cycles count.
- R9: The window length N is a parameter that works for values well above 256. The counter is ceil(log2(N+1)) bits wide, and the default is N = 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Antecedent; starts an attempt when idle |
| resp_i | input | 1 | Consequent; satisfies the attempt inside the window |
| dis_i | input | 1 | Abort; cancels the attempt or blocks its start |
| kill_i | input | 1 | Kill; cancels the attempt or blocks its start |
| fail_o | output | 1 | One-cycle pulse when a window expires unmatched |

## Verification
The rule is tried in several ways:

- A response placed on the first window cycle, on the last window cycle, and on the trigger cycle. These three separate an off-by-one window from a correct one.
- An attempt with no response at all. This pins the failure pulse to exactly cycle N+1 after the trigger.
- An abort or kill placed on the trigger cycle, in mid-window, and on the final cycle. These show that a cancel at any point suppresses the expiry reject, not only a cancel that is held.
- Repeated triggers during a window, and a reset inside a window, in both cases against a pseudo-random stream. These show that a second trigger never restarts the count.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [0:0] {
    RDC_IDLE  = 1'b0,
    RDC_COUNT = 1'b1
  } rdc_state_e;

  function automatic int rdc_cnt_width(input int win);
    return (win < 1) ? 1 : $clog2(win + 1);
  endfunction

endpackage

// File: rtl/rdc_window_cnt.sv
module rdc_window_cnt #(
  parameter int N = 300,
  parameter int W = rdc_pkg::rdc_cnt_width(N)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  localparam logic [W-1:0] LAST_IDX = W'(N);
  localparam logic [W-1:0] FIRST_IDX = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= FIRST_IDX;
    end else if (adv_i) begin
      cnt_q <= cnt_q + FIRST_IDX;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_IDX);

  // R9
  no_cnt_overrun_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i |-> (cnt_q < LAST_IDX));

  // R2
  load_to_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (cnt_q == FIRST_IDX));

endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       trig_i,
  input  logic       resp_i,
  input  logic       dis_i,
  input  logic       kill_i,
  input  logic       last_i,
  output rdc_state_e state_o,
  output logic       load_o,
  output logic       adv_o,
  output logic       expire_o
);

  rdc_state_e state_q, state_d;
  logic       counting;
  logic       cancel;
  logic       start;
  logic       hit;
  logic       finish;

  always_comb begin
    counting = (state_q == RDC_COUNT);
    cancel   = dis_i | kill_i;
    start    = !counting && trig_i && !cancel;
    hit      = counting && resp_i;
    finish   = counting && (cancel || resp_i || last_i);
    expire_o = counting && last_i && !resp_i && !cancel;
    adv_o    = counting && !finish;
    load_o   = start;
    state_d  = state_q;
    if (start)  state_d = RDC_COUNT;
    if (finish) state_d = RDC_IDLE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= RDC_IDLE;
    else       state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    rst_i |=> (state_q == RDC_IDLE));

  // R3
  hit_ends_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hit |=> (state_q == RDC_IDLE));

  // R5
  cancel_ends_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (counting && cancel) |=> (state_q == RDC_IDLE));

endmodule

// File: rtl/rdc_reject.sv
module rdc_reject (
  input  logic clk_i,
  input  logic rst_i,
  input  logic expire_i,
  input  logic dis_i,
  output logic fail_o
);

  logic fail_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) fail_q <= 1'b0;
    else       fail_q <= expire_i && !dis_i;
  end

  assign fail_o = fail_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fail_q |=> !fail_q);

  // R5
  dis_gates_fail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dis_i |=> !fail_q);

endmodule

// File: rtl/range_delay_chk.sv
module range_delay_chk
  import rdc_pkg::*;
#(
  parameter int N = 300
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  input  logic resp_i,
  input  logic dis_i,
  input  logic kill_i,
  output logic fail_o
);

  localparam int W = rdc_cnt_width(N);

  rdc_state_e   state;
  logic         load;
  logic         adv;
  logic         expire;
  logic [W-1:0] cnt;
  logic         last;

  rdc_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .trig_i  (trig_i),
    .resp_i  (resp_i),
    .dis_i   (dis_i),
    .kill_i  (kill_i),
    .last_i  (last),
    .state_o (state),
    .load_o  (load),
    .adv_o   (adv),
    .expire_o(expire)
  );

  rdc_window_cnt #(.N(N), .W(W)) i_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(load),
    .adv_i (adv),
    .cnt_o (cnt),
    .last_o(last)
  );

  rdc_reject i_rej (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .expire_i(expire),
    .dis_i   (dis_i),
    .fail_o  (fail_o)
  );

  // R7
  trig_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == RDC_COUNT && !last && !resp_i && !dis_i && !kill_i)
      |=> (state == RDC_COUNT && cnt == $past(cnt) + W'(1)));

  // R6
  kill_gates_fail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    kill_i |=> !fail_o);

  // R4
  fail_at_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fail_o |-> $past(state == RDC_COUNT && last));

endmodule

// File: tb/test_range_delay_chk.sv
`timescale 1ns / 1ps
module test_range_delay_chk;

  localparam int N = 300;

  logic clk = 1'b0;
  logic rst, trig, resp, dis, kill;
  logic fail;

  int vectors = 0;
  int errors = 0;
  int age = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  range_delay_chk #(.N(N)) i_range_delay_chk (
    .clk_i (clk),
    .rst_i (rst),
    .trig_i(trig),
    .resp_i(resp),
    .dis_i (dis),
    .kill_i(kill),
    .fail_o(fail)
  );

  // Behavioural reference: age = window cycle index of the current cycle, 0 when idle.
  task automatic step(input bit r, input bit t, input bit c, input bit d, input bit k,
                      input string tag);
    bit exp_fail;
    exp_fail = 0;
    rst = r; trig = t; resp = c; dis = d; kill = k;
    if (r) age = 0;
    else if (age == 0) begin
      if (t && !d && !k) age = 1;
    end else if (d || k || c) age = 0;
    else if (age == N) begin
      exp_fail = 1;
      age = 0;
    end else age = age + 1;
    @(posedge clk);
    #1;
    vectors++;
    if (fail !== exp_fail) begin
      errors++;
      $display("FAIL %s: fail_o=%b expected=%b at vector %0d", tag, fail, exp_fail, vectors);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  // trigger, then window cycles 1..N with one event at cycle pos
  task automatic attempt(input int pos, input bit c, input bit d, input bit k, input string tag);
    step(0, 1, 0, 0, 0, tag);
    for (int i = 1; i <= N; i++) begin
      if (i == pos) step(0, 0, c, d, k, tag);
      else          step(0, 0, 0, 0, 0, tag);
    end
    quiet(3, tag);
  endtask

  initial begin
    rst = 1; trig = 0; resp = 0; dis = 0; kill = 0;
    step(1, 1, 0, 0, 0, "R1");
    step(1, 1, 1, 0, 0, "R1");
    quiet(2, "R1");

    attempt(0, 0, 0, 0, "R4");     // no response: pulse at N+1 (R9 large N)
    attempt(0, 0, 0, 0, "R9");
    attempt(1, 1, 0, 0, "R3");     // first window cycle
    attempt(N, 1, 0, 0, "R3");     // last window cycle
    attempt(150, 1, 0, 0, "R3");

    step(0, 1, 1, 0, 0, "R8");     // response on trigger cycle only
    for (int i = 1; i <= N; i++) step(0, 0, 0, 0, 0, "R8");
    quiet(3, "R8");

    attempt(1, 0, 1, 0, "R5");
    attempt(137, 0, 1, 0, "R5");
    attempt(N, 0, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R5");     // dis on trigger: no start
    quiet(N + 3, "R5");

    attempt(1, 0, 0, 1, "R6");
    attempt(N, 0, 0, 1, "R6");
    step(0, 1, 0, 0, 1, "R6");
    quiet(N + 3, "R6");

    step(0, 1, 0, 0, 0, "R2");     // R7: retriggers ignored, incl. final cycle
    for (int i = 1; i <= N; i++) step(0, (i % 7 == 0) || (i == N), 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, "R7");     // starts new attempt while pulse shows
    for (int i = 1; i <= N; i++) step(0, 0, 0, 0, 0, "R7");
    quiet(2, "R7");

    step(0, 1, 0, 0, 0, "R1");     // reset mid-window
    quiet(100, "R1");
    step(1, 0, 0, 0, 0, "R1");
    quiet(N + 5, "R1");

    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, lfsr[0], (lfsr[9:1] == 9'd5), (lfsr[15:6] == 10'd3),
           (lfsr[12:3] == 10'd7), "R2");
    end
    quiet(N + 3, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule